// File: doc/BRIEF.md
# Registered Command Buffer with Delayed Parity Check

This block is the register stage that sits between a memory controller and the DRAM devices on a registered memory module. On every rising clock edge it captures the command/address bus, the clock-enable and termination-control lines and the chip selects. It drives the command/address word on two identical output copies, so each half of the module gets its own load. A mode pin sets how the chip selects are routed. In dual mode two chip-select inputs are each fanned out to an A-side copy and a B-side copy. In quad mode four chip-select inputs pass straight through.

The block checks the integrity of the command/address bus with a parity bit that the host sends one clock after the word it protects. The parity is computed only over words that some active chip select qualified. When the supplied bit disagrees with the computed one, an active-low error line pulses low for one clock. In cycles where no chip select is asserted, the command/address outputs keep their previous value, which saves output toggling.

Top module: `cmd_reg_buffer`

## Requirements
- R1: All outputs are registered. A value present at the inputs before a rising edge appears at the outputs right after that edge.
- R2: In dual mode (`quad_mode_n` = 1), `cs_q_n[0]` and `cs_q_n[2]` both carry `cs_in_n[0]`, and `cs_q_n[1]` and `cs_q_n[3]` both carry `cs_in_n[1]`.
- R3: In quad mode (`quad_mode_n` = 0), `cs_q_n[i]` carries `cs_in_n[i]` for i = 0..3.
- R4: Chip selects are active low. A cycle is qualified when any of `cs_in_n[1:0]` is 0 in dual mode, or when any of `cs_in_n[3:0]` is 0 in quad mode. Only a qualified cycle loads `ca_in` into both `ca_qa` and `ca_qb`. Otherwise both hold their value. The two copies are always equal.
- R5: `cke_q` and `odt_q` follow `cke_in` and `odt_in` every cycle, whether or not any chip select is active. These lines never affect the error output.
- R6: The computed parity is the XOR of all bits of `ca_in` in a qualified cycle. `par_in` sampled at the following edge is compared with it. On a mismatch, `err_n` is 0 for exactly the cycle after that second edge.
- R7: A cycle that is not qualified never causes `err_n` to go low, whatever `par_in` carries in the following cycle.
- R8: A synchronous reset (`rst_n` = 0 at an edge) sets `cs_q_n` to all ones, sets `ca_qa`, `ca_qb`, `cke_q` and `odt_q` to zero, and sets `err_n` to 1.
- R9: Reset clears the pending parity. The first `par_in` sampled after reset causes no error.
- R10: In dual mode `cs_in_n[3:2]` have no effect on the chip-select outputs or on qualification.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| quad_mode_n | input | 1 | 1: dual chip-select mode, 0: quad chip-select mode |
| cs_in_n | input | 4 | Chip selects, active low |
| ca_in | input | CA_W | Command/address word |
| cke_in | input | CKE_W | Clock-enable lines |
| odt_in | input | ODT_W | Termination-control lines |
| par_in | input | 1 | Parity of the previous qualified word |
| ca_qa | output | CA_W | Command/address copy A |
| ca_qb | output | CA_W | Command/address copy B |
| cke_q | output | CKE_W | Registered clock-enable lines |
| odt_q | output | ODT_W | Registered termination-control lines |
| cs_q_n | output | 4 | Routed chip selects, active low |
| err_n | output | 1 | Parity error, active low, one-cycle pulse |

## Verification
The bench uses the defaults: a 22-bit command/address word and two clock-enable and two termination lines. This keeps the XOR reduction wide enough that a single flipped bit anywhere in the word is a realistic mismatch case. Mode switches happen mid-run, so a qualified word followed by a mode change reaches the parity compare together with the new routing. Random chip-select patterns include dual-mode cycles in which only the unused upper selects are low. Those cycles show that qualification looks at the right lines.

// File: rtl/cmd_reg_buffer.sv
module cmd_reg_buffer #(
  parameter int CA_W  = 22,
  parameter int CKE_W = 2,
  parameter int ODT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quad_mode_n,
  input  logic [3:0]       cs_in_n,
  input  logic [CA_W-1:0]  ca_in,
  input  logic [CKE_W-1:0] cke_in,
  input  logic [ODT_W-1:0] odt_in,
  input  logic             par_in,
  output logic [CA_W-1:0]  ca_qa,
  output logic [CA_W-1:0]  ca_qb,
  output logic [CKE_W-1:0] cke_q,
  output logic [ODT_W-1:0] odt_q,
  output logic [3:0]       cs_q_n,
  output logic             err_n
);

  localparam int HALF = 2;

  logic       qual;
  logic [3:0] cs_route;
  logic       par_pend;
  logic       par_calc;

  assign qual = quad_mode_n ? ~&cs_in_n[HALF-1:0] : ~&cs_in_n;

  for (genvar g = 0; g < 4; g++) begin : g_route
    assign cs_route[g] = quad_mode_n ? cs_in_n[g % HALF] : cs_in_n[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca_qa    <= '0;
      ca_qb    <= '0;
      cke_q    <= '0;
      odt_q    <= '0;
      cs_q_n   <= '1;
      par_pend <= 1'b0;
      par_calc <= 1'b0;
      err_n    <= 1'b1;
    end else begin
      if (qual) begin
        ca_qa <= ca_in;
        ca_qb <= ca_in;
      end
      cke_q    <= cke_in;
      odt_q    <= odt_in;
      cs_q_n   <= cs_route;
      par_pend <= qual;
      par_calc <= ^ca_in;
      err_n    <= ~(par_pend & (par_calc ^ par_in));
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (cs_q_n == 4'hF && err_n && ca_qa == '0 && cke_q == '0)); // R8

  AST_DUAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    quad_mode_n |=> (cs_q_n[2] == cs_q_n[0] && cs_q_n[3] == cs_q_n[1])); // R2

  AST_QUAD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !quad_mode_n |=> (cs_q_n == $past(cs_in_n))); // R3

  AST_CA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_mode_n ? &cs_in_n[1:0] : &cs_in_n) |=> ($stable(ca_qa) && $stable(ca_qb))); // R4

  AST_COPIES_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    ca_qa == ca_qb); // R4

  AST_CTRL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cke_q == $past(cke_in) && odt_q == $past(odt_in))); // R5

  AST_UNQUAL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((quad_mode_n ? &cs_in_n[1:0] : &cs_in_n) ##1 rst_n) |=> err_n); // R7

  AST_NO_ERR_AFTER_RST: assert property (@(posedge clk)
    (!rst_n ##1 rst_n) |=> err_n); // R9

endmodule

// File: tb/test_cmd_reg_buffer.sv
module test_cmd_reg_buffer;
  localparam int CLK_P = 10;
  localparam int CA_W  = 22;
  localparam int CKE_W = 2;
  localparam int ODT_W = 2;

  logic             clk = 1'b0;
  logic             rst_n, quad_mode_n, par_in;
  logic [3:0]       cs_in_n;
  logic [CA_W-1:0]  ca_in;
  logic [CKE_W-1:0] cke_in;
  logic [ODT_W-1:0] odt_in;
  logic [CA_W-1:0]  ca_qa, ca_qb;
  logic [CKE_W-1:0] cke_q;
  logic [ODT_W-1:0] odt_q;
  logic [3:0]       cs_q_n;
  logic             err_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [CA_W-1:0]  e_ca;
  logic [CKE_W-1:0] e_cke;
  logic [ODT_W-1:0] e_odt;
  logic [3:0]       e_cs;
  logic             e_err, e_pend, e_calc;

  always #(CLK_P/2) clk = ~clk;

  cmd_reg_buffer #(.CA_W(CA_W), .CKE_W(CKE_W), .ODT_W(ODT_W)) i_cmd_reg_buffer (
    .clk(clk), .rst_n(rst_n), .quad_mode_n(quad_mode_n), .cs_in_n(cs_in_n),
    .ca_in(ca_in), .cke_in(cke_in), .odt_in(odt_in), .par_in(par_in),
    .ca_qa(ca_qa), .ca_qb(ca_qb), .cke_q(cke_q), .odt_q(odt_q),
    .cs_q_n(cs_q_n), .err_n(err_n));

  function automatic logic is_qual(logic mode_n, logic [3:0] cs);
    return mode_n ? ~&cs[1:0] : ~&cs;
  endfunction

  function automatic logic [3:0] route(logic mode_n, logic [3:0] cs);
    return mode_n ? {cs[1], cs[0], cs[1], cs[0]} : cs;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1/R4 ca_qa", 64'(ca_qa), 64'(e_ca));
    chk("R4 ca_qb", 64'(ca_qb), 64'(e_ca));
    chk("R5 cke_q", 64'(cke_q), 64'(e_cke));
    chk("R5 odt_q", 64'(odt_q), 64'(e_odt));
    chk("R2/R3/R10 cs_q_n", 64'(cs_q_n), 64'(e_cs));
    chk("R6/R7 err_n", 64'(err_n), 64'(e_err));
  endtask

  // Drive at a falling edge and advance the model by the next rising edge.
  task automatic step(logic r, logic m, logic [3:0] cs, logic [CA_W-1:0] ca,
                      logic [CKE_W-1:0] ck, logic [ODT_W-1:0] od, logic p);
    rst_n = r; quad_mode_n = m; cs_in_n = cs; ca_in = ca;
    cke_in = ck; odt_in = od; par_in = p;
    if (!r) begin
      e_ca = '0; e_cke = '0; e_odt = '0; e_cs = 4'hF;
      e_err = 1'b1; e_pend = 1'b0; e_calc = 1'b0;
    end else begin
      e_err = ~(e_pend & (e_calc ^ p));
      if (is_qual(m, cs)) e_ca = ca;
      e_cke = ck; e_odt = od; e_cs = route(m, cs);
      e_pend = is_qual(m, cs); e_calc = ^ca;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    logic [CA_W-1:0] ca;
    logic [3:0] cs;
    logic m, bad;
    void'($urandom(32'd2024));
    @(negedge clk);
    // R8: reset state
    step(1'b0, 1'b1, 4'h0, '1, '1, '1, 1'b1);
    step(1'b0, 1'b0, 4'h0, '1, '1, '1, 1'b0);
    // R9: wrong parity right after reset gives no error
    step(1'b1, 1'b1, 4'hE, 22'h15A5A5, 2'b01, 2'b10, 1'b1);
    // R6: correct parity, then a deliberate mismatch
    step(1'b1, 1'b1, 4'hD, 22'h000003, 2'b10, 2'b01, ^22'h15A5A5);
    step(1'b1, 1'b1, 4'hF, 22'h3FFFFF, 2'b11, 2'b11, 1'b1);
    // R10: only upper selects low in dual mode; R7: garbage parity
    step(1'b1, 1'b1, 4'h3, 22'h2AAAAA, 2'b00, 2'b00, 1'b1);
    step(1'b1, 1'b1, 4'h3, 22'h111111, 2'b01, 2'b01, 1'b0);
    // R3: quad mode, upper selects qualify now
    step(1'b1, 1'b0, 4'h7, 22'h000001, 2'b00, 2'b11, 1'b0);
    step(1'b1, 1'b0, 4'hB, 22'h000000, 2'b10, 2'b10, 1'b0);
    step(1'b1, 1'b0, 4'hF, 22'h0ABCDE, 2'b10, 2'b10, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      m   = $urandom_range(0, 3) != 0;
      cs  = 4'($urandom);
      if ($urandom_range(0, 3) == 0) cs = 4'hF;
      ca  = CA_W'($urandom);
      bad = $urandom_range(0, 4) == 0;
      step(($urandom_range(0, 199) != 0), m, cs, ca,
           CKE_W'($urandom), ODT_W'($urandom),
           e_pend ? (e_calc ^ bad) : 1'($urandom));
    end
    // R8: reset mid-run, then R9 again
    step(1'b0, 1'b1, 4'h0, '1, '1, '1, 1'b0);
    step(1'b1, 1'b0, 4'h0, 22'h000001, 2'b00, 2'b00, 1'b1);
    step(1'b1, 1'b0, 4'hF, 22'h000000, 2'b00, 2'b00, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule